// File: doc/BRIEF.md
# Two-Wire Bus Master with Command Mailbox

This block is a master for a two-wire serial bus (I2C style, 7-bit addressing). A host drives it through a small register port of 16-bit words. The host first loads up to two outgoing bytes into a data register. It then writes one command word, and that write starts the transfer at once. Each command carries its own target address, its own direction and a byte count of one or two. On every command the block emits the address byte and then moves the bytes.

Completion and failure are recorded in sticky event bits, and a level interrupt is formed from them. A command can keep ownership of the bus. In that case the block leaves out the STOP, and the next command opens with a repeated START. This lets an offset write and a data read chain into one bus transaction.

The clock line is generated from a fixed divider parameter. Both lines are open-drain: the block only pulls a line low or releases it. The line inputs pass through two-flop synchronizers before use, and a target that holds the clock line low simply delays the high phase.

Top module: `i2cm_mbox`

## Requirements
- R1: After reset all event bits and the interrupt enable read as 0, the interrupt output is 0, both line drivers are released (`scl_oe`=0, `sda_oe`=0), and the accepted-command register reads 0.
- R2: Register offset 0x6 takes the command word. The word is acted on only when bits 15:14 equal 2'b10, and any other word is ignored without bus activity. In the word, bits 7:1 give the target address, bit 10=1 means write and 0 means read, bit 11=1 means two bytes and 0 means one, and bit 13=1 keeps the bus. The first byte on the wire is the address in bits 7:1 with bit 0 = 0 for a write and 1 for a read.
- R3: A write sends bits 7:0 of the data register (offset 0x4) first, followed by bits 15:8 when two bytes are requested.
- R4: A read clears the read register (offset 0x8) at the command, then places the first received byte in bits 7:0 and the second in bits 15:8. The master ACKs every received byte except the last byte of the command, which it NACKs.
- R5: At offset 0x0, bit 13 means error, bit 14 means write finished and bit 15 means read finished. At most one event is raised per cycle. Writing 1 to a bit clears it, and an event raised in the same cycle as its clear wins.
- R6: A command with the keep bit clear ends with a STOP. With the keep bit set no STOP follows and the clock line stays low. The next accepted command then opens with a repeated START.
- R7: A NACK on the address byte or on any written byte raises the error bit only. The remaining bytes are dropped, and a STOP is issued even when the keep bit is set.
- R8: The interrupt output is 1 exactly when some bit at offset 0x0 is set together with the same bit of the enable register at offset 0x2.
- R9: A command word written while a transfer is in progress is ignored.
- R10: Offsets 0x2, 0x4 and 0x8 read back their registers. Offset 0xA returns the last accepted command word, and offset 0x6 reads as 0.
- R11: While bytes move and the target does not stretch, the clock line period is 4×`CLK_DIV` cycles. During a data bit, SDA changes only while SCL is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write byte offset |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read byte offset |
| rd_data | output | 16 | Register read data (combinational) |
| irq | output | 1 | Level interrupt |
| scl_i | input | 1 | Clock line as seen on the pad |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_i | input | 1 | Data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
The sequencer raising a "finished" event and the host write-one-to-clear of that same bit can land in the same cycle. To force this, the bench enables only the write-finished bit and holds a clear of it on the register port during every cycle of a transfer. The end of the transfer therefore always meets a clear. The event must win for one cycle, so the interrupt must pulse high for exactly one cycle and the bit must then read as 0. A separate per-clock comparison checks the interrupt against the status read port and the bench's own copy of the enable register.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  // register byte offsets
  localparam logic [3:0] OFS_EVT  = 4'h0;
  localparam logic [3:0] OFS_IEN  = 4'h2;
  localparam logic [3:0] OFS_TXD  = 4'h4;
  localparam logic [3:0] OFS_CMD  = 4'h6;
  localparam logic [3:0] OFS_RXD  = 4'h8;
  localparam logic [3:0] OFS_LAST = 4'hA;
  // event bit positions; order err, write, read
  localparam int EV_LO   = 13;
  localparam int EV_NUM  = 3;
  // command word fields
  localparam int CMD_WR   = 10;
  localparam int CMD_TWO  = 11;
  localparam int CMD_KEEP = 13;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_RSTART, ST_BITS, ST_STOP, ST_HOLD
  } eng_st_t;

  typedef struct packed {
    logic [6:0]  addr;
    logic        wr;
    logic        two;
    logic        keep;
    logic [15:0] wdata;
  } cmd_t;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;

  assign tick = (cnt == LAST);
endmodule

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] sr;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sr <= '1;
      else        sr <= {sr[STAGES-2:0], d[g]};
    assign q[g] = sr[STAGES-1];
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        scl_s,
  input  logic        sda_s,
  input  logic        go,
  input  cmd_t        cmd,
  output logic        busy,
  output logic        ev_err,
  output logic        ev_wr,
  output logic        ev_rd,
  output logic [15:0] rdata,
  output logic        scl_low,
  output logic        sda_low
);
  eng_st_t    st;
  logic [1:0] ph;
  logic [3:0] bitc;
  logic [1:0] bidx;
  logic [7:0] sh;
  logic       rbit;
  cmd_t       c;
  logic       txm, lastb, drive;

  assign busy  = (st != ST_IDLE) && (st != ST_HOLD);
  assign txm   = (bidx == 2'd0) || c.wr;
  assign lastb = (bidx == (c.two ? 2'd2 : 2'd1));
  assign drive = (bitc == 4'd8) ? (!txm && !lastb) : (txm && !sh[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= '0; bitc <= '0; bidx <= '0; sh <= '0; rbit <= 1'b1;
      rdata <= '0; c <= '0; scl_low <= 1'b0; sda_low <= 1'b0;
      ev_err <= 1'b0; ev_wr <= 1'b0; ev_rd <= 1'b0;
    end else begin
      ev_err <= 1'b0; ev_wr <= 1'b0; ev_rd <= 1'b0;
      if (go && !busy) begin
        c <= cmd; sh <= {cmd.addr, ~cmd.wr}; bidx <= '0; bitc <= '0; ph <= '0;
        if (!cmd.wr) rdata <= '0;
        st <= (st == ST_HOLD) ? ST_RSTART : ST_START;
      end else if (tick) begin
        case (st)
          ST_START:
            if (ph == 2'd0) begin sda_low <= 1'b1; ph <= 2'd1; end
            else begin scl_low <= 1'b1; ph <= 2'd0; st <= ST_BITS; end
          ST_RSTART, ST_STOP:
            case (ph)
              2'd0: begin sda_low <= (st == ST_STOP); ph <= 2'd1; end
              2'd1: begin scl_low <= 1'b0; ph <= 2'd2; end
              2'd2: if (scl_s) ph <= 2'd3;
              default: begin
                if (st == ST_STOP) begin sda_low <= 1'b0; st <= ST_IDLE; ph <= 2'd0; end
                else begin sda_low <= 1'b1; st <= ST_START; ph <= 2'd1; end
              end
            endcase
          ST_BITS:
            case (ph)
              2'd0: begin sda_low <= drive; ph <= 2'd1; end
              2'd1: begin scl_low <= 1'b0; ph <= 2'd2; end
              2'd2: if (scl_s) begin rbit <= sda_s; ph <= 2'd3; end
              default: begin
                scl_low <= 1'b1; ph <= 2'd0;
                if (bitc != 4'd8) begin
                  sh <= {sh[6:0], rbit}; bitc <= bitc + 4'd1;
                end else begin
                  bitc <= '0;
                  if (txm && rbit) begin
                    ev_err <= 1'b1; st <= ST_STOP;
                  end else begin
                    if (!txm) begin
                      if (bidx == 2'd2) rdata[15:8] <= sh;
                      else              rdata[7:0]  <= sh;
                    end
                    if (lastb) begin
                      ev_wr <= c.wr; ev_rd <= !c.wr;
                      st <= c.keep ? ST_HOLD : ST_STOP;
                    end else begin
                      bidx <= bidx + 2'd1;
                      sh <= (bidx == 2'd0) ? c.wdata[7:0] : c.wdata[15:8];
                    end
                  end
                end
              end
            endcase
          default: ;
        endcase
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (!scl_low && !sda_low)); // R1
  AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BITS && !scl_low && $past(!scl_low)) |-> $stable(sda_low)); // R11
  AST_NACK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |-> (st == ST_STOP && scl_low)); // R7
  AST_KEEP_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_wr || ev_rd) && c.keep) |-> (st == ST_HOLD && scl_low && !sda_low)); // R6
endmodule

// File: rtl/i2cm_mbox.sv
module i2cm_mbox
  import i2cm_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [3:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic        irq,
  input  logic        scl_i,
  output logic        scl_oe,
  input  logic        sda_i,
  output logic        sda_oe
);
  logic              tick, busy, ev_err, ev_wr, ev_rd, scl_s, sda_s, accept, evt_wr;
  logic [15:0]       ien_q, txd_q, last_q, rxd, evt_word;
  logic [EV_NUM-1:0] evt_q, evt_set;
  cmd_t              cmd;

  i2cm_tick #(.DIV(CLK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));
  i2cm_sync #(.N(2), .STAGES(2)) u_sync (.clk(clk), .rst_n(rst_n),
    .d({scl_i, sda_i}), .q({scl_s, sda_s}));

  assign accept = wr_en && (wr_addr == OFS_CMD) && (wr_data[15:14] == 2'b10) && !busy;
  assign evt_wr = wr_en && (wr_addr == OFS_EVT);
  assign cmd    = '{addr: wr_data[7:1], wr: wr_data[CMD_WR], two: wr_data[CMD_TWO],
                    keep: wr_data[CMD_KEEP], wdata: txd_q};

  i2cm_engine u_eng (.clk(clk), .rst_n(rst_n), .tick(tick), .scl_s(scl_s), .sda_s(sda_s),
    .go(accept), .cmd(cmd), .busy(busy), .ev_err(ev_err), .ev_wr(ev_wr), .ev_rd(ev_rd),
    .rdata(rxd), .scl_low(scl_oe), .sda_low(sda_oe));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ien_q <= '0; txd_q <= '0; last_q <= '0;
    end else begin
      if (wr_en && wr_addr == OFS_IEN) ien_q <= wr_data;
      if (wr_en && wr_addr == OFS_TXD) txd_q <= wr_data;
      if (accept) last_q <= wr_data;
    end

  assign evt_set = {ev_rd, ev_wr, ev_err};
  for (genvar g = 0; g < EV_NUM; g++) begin : g_evt
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) evt_q[g] <= 1'b0;
      else evt_q[g] <= evt_set[g] | (evt_q[g] & ~(evt_wr & wr_data[EV_LO+g]));
  end

  assign evt_word = {evt_q, {EV_LO{1'b0}}};
  assign irq      = |(evt_word & ien_q);

  always_comb
    case (rd_addr)
      OFS_EVT:  rd_data = evt_word;
      OFS_IEN:  rd_data = ien_q;
      OFS_TXD:  rd_data = txd_q;
      OFS_RXD:  rd_data = rxd;
      OFS_LAST: rd_data = last_q;
      default:  rd_data = '0;
    endcase

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr && evt_wr && wr_data[EV_LO+1]) |=> evt_q[1]); // R5
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_err, ev_wr, ev_rd})); // R5
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wr_addr == OFS_CMD) |=> $stable(last_q)); // R9
endmodule

// File: tb/test_i2cm_mbox.sv
module test_i2cm_mbox;
  localparam int DIV = 4;
  localparam logic [6:0] TGT = 7'h52;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data, en_model = '0;
  logic irq, scl_oe, sda_oe, s_sda_low = 1'b0;
  wire scl = !scl_oe;
  wire sda = !(sda_oe || s_sda_low);

  i2cm_mbox #(.CLK_DIV(DIV)) i_i2cm_mbox (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq), .scl_i(scl), .scl_oe(scl_oe), .sda_i(sda), .sda_oe(sda_oe));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, irq_bad = 0;
  bit run_chk = 0, done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // target model state
  string evq[$];
  logic [7:0] rxq[$], rdsrc[$];
  bit mackq[$];
  int riseq[$];
  int bitc = 0, dcnt = 0, nack_at = 0;
  bit active = 0, is_addr = 0, txm = 0, mack = 0, next_tx = 0, owned = 0;
  bit ps = 1, psda = 1;
  logic [7:0] shreg = '0, txb = '0;

  always @(negedge clk) begin
    if (scl && ps && psda && !sda) begin
      evq.push_back(owned ? "R" : "S"); owned = 1; bitc = -1; active = 1;
      is_addr = 1; txm = 0; dcnt = 0; s_sda_low = 0;
    end else if (scl && ps && !psda && sda) begin
      evq.push_back("P"); owned = 0; active = 0; s_sda_low = 0;
    end else if (active && !ps && scl) begin
      riseq.push_back(cyc);
      if (bitc >= 0 && bitc < 8 && !txm) shreg = {shreg[6:0], sda};
      if (bitc == 8 && txm) begin mack = !sda; mackq.push_back(mack); end
    end else if (active && ps && !scl) begin
      bitc++;
      if (bitc >= 0 && bitc < 8) begin
        if (txm) s_sda_low = !txb[7-bitc];
      end else if (bitc == 8) begin
        s_sda_low = 0;
        if (!txm) begin
          rxq.push_back(shreg);
          if (is_addr) begin
            next_tx = shreg[0];
            if (shreg[7:1] == TGT) s_sda_low = 1; else active = 0;
          end else begin
            dcnt++;
            s_sda_low = (dcnt != nack_at);
          end
        end
      end else begin
        bitc = 0; s_sda_low = 0;
        if (is_addr) begin
          is_addr = 0; txm = next_tx;
          if (txm) begin
            txb = (rdsrc.size() > 0) ? rdsrc.pop_front() : 8'hFF; s_sda_low = !txb[7];
          end
        end else if (txm) begin
          if (mack) begin
            txb = (rdsrc.size() > 0) ? rdsrc.pop_front() : 8'hFF; s_sda_low = !txb[7];
          end else active = 0;
        end
      end
    end
    ps = scl; psda = sda;
  end

  // per-clock interrupt comparison against the bench's enable copy (R8)
  always @(posedge clk) begin
    #5;
    if (run_chk && rd_addr == 4'h0 && irq !== |(rd_data & en_model)) irq_bad++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_s(input string tag, input string act, input string exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=\"%s\" expected=\"%s\"", tag, act, exp);
    end
  endtask

  function automatic string evs();
    string s = "";
    foreach (evq[i]) s = {s, evq[i]};
    return s;
  endfunction

  function automatic logic [31:0] packrx();
    logic [31:0] r = '0;
    foreach (rxq[i]) r = (r << 8) | 32'(rxq[i]);
    return r;
  endfunction

  task automatic clr_logs();
    evq.delete(); rxq.delete(); mackq.delete(); riseq.delete();
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    if (a == 4'h2) en_model = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk); rd_addr = a; #1; v = rd_data; rd_addr = 4'h0;
  endtask

  task automatic wait_ev(input logic [15:0] mask, input string tag);
    bit seen = 0;
    for (int i = 0; i < 4000 && !seen; i++) begin
      @(posedge clk); #5;
      if ((rd_data & mask) != 0) seen = 1;
    end
    if (!seen) chk({tag, " event timeout"}, 0, 1);
    repeat (40) @(posedge clk);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int pulses;
    repeat (3) @(negedge clk);
    rst_n = 1;
    run_chk = 1;
    repeat (2) @(negedge clk);
    // R1 reset state
    reg_rd(4'h0, v); chk("R1 events", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 lines", {scl_oe, sda_oe}, 0);
    reg_rd(4'hA, v); chk("R1 last cmd", v, 0);

    // R10 readbacks
    reg_wr(4'h4, 16'h1234); reg_rd(4'h4, v); chk("R10 txd", v, 16'h1234);
    reg_wr(4'h2, 16'h0000); reg_rd(4'h6, v); chk("R10 cmd reads 0", v, 0);

    // two-byte write, STOP at end
    clr_logs();
    reg_wr(4'h6, 16'h8CA4);
    wait_ev(16'h4000, "R3");
    chk_s("R6 stop", evs(), "SP");
    chk("R2 R3 bytes", packrx(), 32'hA43412);
    chk("R3 count", rxq.size(), 3);
    reg_rd(4'h0, v); chk("R5 write done", v, 16'h4000);
    chk("R11 scl period", (riseq.size() > 2) ? riseq[2] - riseq[1] : 0, 4 * DIV);
    reg_rd(4'hA, v); chk("R10 last cmd", v, 16'h8CA4);

    // two-byte read
    clr_logs(); rdsrc = '{8'hAB, 8'hCD};
    reg_wr(4'h6, 16'h88A4);
    wait_ev(16'h8000, "R4");
    chk("R2 read addr byte", packrx(), 32'hA5);
    reg_rd(4'h8, v); chk("R4 read data", v, 16'hCDAB);
    chk("R4 ack count", mackq.size(), 2);
    chk("R4 ack pattern", (mackq.size() == 2) ? {mackq[0], mackq[1]} : 2'b11, 2'b10);
    reg_rd(4'h0, v); chk("R5 both events", v, 16'hC000);

    // write-one-to-clear
    reg_wr(4'h0, 16'h4000); reg_rd(4'h0, v); chk("R5 w1c", v, 16'h8000);

    // interrupt gating
    reg_wr(4'h2, 16'h8000); chk("R8 irq on", irq, 1);
    reg_wr(4'h2, 16'h2000); chk("R8 irq masked", irq, 0);
    reg_wr(4'h0, 16'hE000); reg_rd(4'h0, v); chk("R5 clear all", v, 0);

    // keep bus, then chained read with repeated start
    clr_logs();
    reg_wr(4'h4, 16'h0007);
    reg_wr(4'h6, 16'hA4A4);
    wait_ev(16'h4000, "R6");
    chk_s("R6 no stop", evs(), "S");
    chk("R6 scl held low", scl_oe, 1);
    rdsrc = '{8'h5A};
    reg_wr(4'h6, 16'h80A4);
    wait_ev(16'h8000, "R6");
    chk_s("R6 repeated start", evs(), "SRP");
    chk("R6 chain bytes", packrx(), 32'hA407A5);
    reg_rd(4'h8, v); chk("R4 one byte read", v, 16'h005A);
    chk("R4 last nack", (mackq.size() == 1) ? mackq[0] : 1'b1, 0);
    reg_wr(4'h0, 16'hE000);

    // address NACK with keep set
    clr_logs();
    reg_wr(4'h6, 16'hA422);
    wait_ev(16'h2000, "R7");
    chk_s("R7 stop despite keep", evs(), "SP");
    reg_rd(4'h0, v); chk("R7 error only", v, 16'h2000);
    chk("R7 addr only", packrx(), 32'h22);
    reg_wr(4'h0, 16'hE000);

    // data NACK on first written byte
    clr_logs(); nack_at = 1;
    reg_wr(4'h4, 16'h5566);
    reg_wr(4'h6, 16'h8CA4);
    wait_ev(16'h2000, "R7");
    chk("R7 abort rest", packrx(), 32'hA466);
    chk_s("R7 data nack stop", evs(), "SP");
    reg_rd(4'h0, v); chk("R7 data nack event", v, 16'h2000);
    nack_at = 0;
    reg_wr(4'h0, 16'hE000);

    // non-native tag ignored
    clr_logs();
    reg_wr(4'h6, 16'h4CA4);
    repeat (200) @(negedge clk);
    chk_s("R2 bad tag no bus", evs(), "");
    reg_rd(4'h0, v); chk("R2 bad tag no event", v, 0);
    reg_rd(4'hA, v); chk("R2 bad tag not accepted", v, 16'h8CA4);

    // command while busy ignored
    clr_logs();
    reg_wr(4'h4, 16'h0099);
    reg_wr(4'h6, 16'h84A4);
    repeat (20) @(negedge clk);
    reg_wr(4'h6, 16'h8422);
    wait_ev(16'h4000, "R9");
    chk("R9 only first", packrx(), 32'hA499);
    reg_rd(4'hA, v); chk("R9 last cmd kept", v, 16'h84A4);
    reg_wr(4'h0, 16'hE000);

    // event and clear in the same cycle
    clr_logs();
    reg_wr(4'h2, 16'h4000);
    reg_wr(4'h6, 16'h84A4);
    @(negedge clk); wr_en = 1; wr_addr = 4'h0; wr_data = 16'h4000;
    pulses = 0;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #5;
      if (irq) pulses++;
      if (evq.size() > 0 && evq[$] == "P") break;
    end
    @(negedge clk); wr_en = 0;
    chk("R5 set wins pulse", pulses, 1);
    reg_rd(4'h0, v); chk("R5 cleared after", v, 0);

    run_chk = 0;
    chk("R8 per-clock irq", irq_bad, 0);
    done = 1;
    summary();
    $finish;
  end
endmodule